// File: doc/BRIEF.md
# Toggle-Stepped Debug Observation Multiplexer

This block brings a wide bundle of internal chip signals out to a small set of debug pins after fabrication. The probed bundle is split into equal groups, and one group at a time is driven onto the observation outputs through a registered multiplexer. With the default sizes, 96 signals form sixteen 6-bit groups. Seven pins cover all of them: six outputs and one step input.

Which group is shown comes from a small counter. A single asynchronous step pin drives that counter. Every level change on the pin, whether it rises or falls, moves the selection forward by one group. The counter wraps after the last group. No select bus is needed.

In use, a tester or probe station flips the step pin and reads the six outputs after each flip. This lets it follow one instruction through the fetch, decode, execute and write-back groups.

Top module: `obs_toggle_mux`

## Requirements
- R1: While reset is high the observation outputs are all zero. In the first cycle after reset is released, the outputs show group 0.
- R2: Reset never counts as a step, whatever the step pin's level. The selection stays at group 0 after release until the pin actually changes level.
- R3: A rising level change on the step pin advances the selection by exactly one group.
- R4: A falling level change on the step pin also advances the selection by exactly one group.
- R5: From the last group (15), one more level change returns the selection to group 0.
- R6: When group k is selected, observation output bit i carries probe bit 6k+i, for i from 0 to 5.
- R7: The step pin may change between clock edges. The outputs still show the old group after the third rising edge that follows the change, and the new group after the fourth.
- R8: While the step pin holds its level, the selection does not change. The outputs follow changes on the probe bundle with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| obs_step_pin | input | 1 | Asynchronous step input; each level change selects the next group |
| probe_bus | input | 96 | Internal signals to observe, grouped six bits at a time |
| obs_pins | output | 6 | Registered observation outputs carrying the selected group |

## Verification
The checks assume that the step pin holds each level for at least one full clock period. A shorter pulse can vanish inside the synchronizer, and a step would then be missed. The checks also assume the probe bundle is synchronous to the clock. The stimulus changes the pin only on falling clock edges and holds every level for at least four cycles. The pin is also flipped while reset is held, so the reset seeding is exercised with the pin at both levels.

// File: rtl/obs_mux_pkg.sv
package obs_mux_pkg;
  localparam int OBS_GROUP_W_DEF  = 6;
  localparam int OBS_GROUPS_DEF   = 16;
  localparam int OBS_SYNC_DEF     = 2;
endpackage

// File: rtl/obs_pin_sync.sv
module obs_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic pin_sync
);
  logic [STAGES-1:0] chain_q;

  // Reset seeds every stage with the live pin level so no edge appears later.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          chain_q[0] <= pin_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= pin_async;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/obs_step_ctr.sv
module obs_step_ctr #(
  parameter int NUM_GROUPS = 16,
  localparam int SEL_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_raw,
  input  logic             pin_sync,
  output logic [SEL_W-1:0] sel
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_GROUPS - 1);

  logic prev_q;
  logic toggle;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= pin_raw;
    else     prev_q <= pin_sync;
  end

  assign toggle = pin_sync ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (toggle) begin
      if (sel == LAST) sel <= '0;
      else             sel <= sel + 1'b1;
    end
  end
endmodule

// File: rtl/obs_group_mux.sv
module obs_group_mux #(
  parameter int GROUP_W    = 6,
  parameter int NUM_GROUPS = 16,
  localparam int SEL_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int BUS_W  = GROUP_W * NUM_GROUPS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BUS_W-1:0]   bus,
  input  logic [SEL_W-1:0]   sel,
  output logic [GROUP_W-1:0] out
);
  logic [GROUP_W-1:0] grp [NUM_GROUPS];
  logic [GROUP_W-1:0] pick;

  generate
    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
      assign grp[k] = bus[k*GROUP_W +: GROUP_W];
    end
  endgenerate

  always_comb begin
    pick = '0;
    for (int k = 0; k < NUM_GROUPS; k++) begin
      if (sel == SEL_W'(k)) pick = grp[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out <= '0;
    else     out <= pick;
  end
endmodule

// File: rtl/obs_toggle_mux.sv
module obs_toggle_mux
  import obs_mux_pkg::*;
#(
  parameter int GROUP_W     = OBS_GROUP_W_DEF,
  parameter int NUM_GROUPS  = OBS_GROUPS_DEF,
  parameter int SYNC_STAGES = OBS_SYNC_DEF,
  localparam int SEL_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int BUS_W = GROUP_W * NUM_GROUPS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               obs_step_pin,
  input  logic [BUS_W-1:0]   probe_bus,
  output logic [GROUP_W-1:0] obs_pins
);
  logic             pin_s;
  logic [SEL_W-1:0] sel_q;

  obs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_async(obs_step_pin), .pin_sync(pin_s)
  );

  obs_step_ctr #(.NUM_GROUPS(NUM_GROUPS)) u_ctr (
    .clk(clk), .rst(rst), .pin_raw(obs_step_pin), .pin_sync(pin_s), .sel(sel_q)
  );

  obs_group_mux #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) u_mux (
    .clk(clk), .rst(rst), .bus(probe_bus), .sel(sel_q), .out(obs_pins)
  );
endmodule

// File: rtl/obs_toggle_mux_chk.sv
module obs_toggle_mux_chk #(
  parameter int GROUP_W    = 6,
  parameter int NUM_GROUPS = 16,
  localparam int SEL_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int BUS_W = GROUP_W * NUM_GROUPS
) (
  input logic               clk,
  input logic               rst,
  input logic               obs_step_pin,
  input logic [BUS_W-1:0]   probe_bus,
  input logic [GROUP_W-1:0] obs_pins,
  input logic [SEL_W-1:0]   sel_q
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_GROUPS - 1);

  logic               rst_d = 1'b0;
  logic               pin_d = 1'b0;
  logic [1:0]         quiet = 2'd0;
  logic [GROUP_W-1:0] exp_grp;

  assign exp_grp = probe_bus[int'(sel_q)*GROUP_W +: GROUP_W];

  always_ff @(posedge clk) begin
    rst_d <= rst;
    pin_d <= obs_step_pin;
    if (rst || obs_step_pin != pin_d) quiet <= 2'd0;
    else if (quiet != 2'd3)          quiet <= quiet + 2'd1;
  end

  // R1
  always @(posedge clk) begin
    if (rst_d) begin
      reset_clear_chk: assert (obs_pins == '0 && sel_q == '0);
    end
  end

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sel_q) && $past(sel_q) != LAST) |-> sel_q == SEL_W'($past(sel_q) + 1'b1));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sel_q) && $past(sel_q) == LAST) |-> sel_q == '0);

  // R6
  group_map_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> obs_pins == $past(exp_grp));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    quiet == 2'd3 |=> $stable(sel_q));
endmodule

bind obs_toggle_mux obs_toggle_mux_chk #(
  .GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)
) u_chk (
  .clk(clk), .rst(rst), .obs_step_pin(obs_step_pin),
  .probe_bus(probe_bus), .obs_pins(obs_pins), .sel_q(sel_q)
);

// File: tb/obs_toggle_mux_test.sv
module obs_toggle_mux_test;
  localparam int GW = 6;
  localparam int NG = 16;
  localparam int BW = GW * NG;
  localparam int NV = 19;

  // each entry: {pin level, expected group}
  localparam logic [4:0] VEC [NV] = '{
    5'b1_0001, 5'b0_0010, 5'b0_0010, 5'b1_0011, 5'b0_0100,
    5'b1_0101, 5'b0_0110, 5'b1_0111, 5'b0_1000, 5'b1_1001,
    5'b1_1001, 5'b0_1010, 5'b1_1011, 5'b0_1100, 5'b1_1101,
    5'b0_1110, 5'b1_1111, 5'b0_0000, 5'b1_0001
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pin = 1'b0;
  logic [BW-1:0] bus = '0;
  logic [GW-1:0] obs;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  obs_toggle_mux uut (
    .clk(clk), .rst(rst), .obs_step_pin(pin), .probe_bus(bus), .obs_pins(obs)
  );

  function automatic logic [GW-1:0] gval(int k, int salt);
    return GW'(k * 3 + salt);
  endfunction

  function automatic logic [BW-1:0] make_bus(int salt);
    logic [BW-1:0] b;
    for (int k = 0; k < NG; k++) b[k*GW +: GW] = gval(k, salt);
    return b;
  endfunction

  task automatic check(string tag, logic [GW-1:0] act, logic [GW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step_to(logic lvl);
    @(negedge clk) pin = lvl;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    bus = make_bus(5);
    repeat (3) @(posedge clk);
    @(negedge clk) check("R1 outputs zero in reset", obs, '0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 group 0 after release", obs, gval(0, 5));

    begin : walk
      logic prev_pin = 1'b0;
      for (int i = 0; i < NV; i++) begin
        string tag;
        step_to(VEC[i][4]);
        if (VEC[i][3:0] == 4'd0)          tag = "R5 wrap";
        else if (VEC[i][4] == prev_pin)   tag = "R8 hold";
        else if (VEC[i][4])               tag = "R3 rise step";
        else                              tag = "R4 fall step";
        check(tag, obs, gval(int'(VEC[i][3:0]), 5));
        prev_pin = VEC[i][4];
      end
    end

    // R7 latency: group 1 now, pin high
    @(negedge clk) pin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) check("R7 old group after 3 edges", obs, gval(1, 5));
    @(posedge clk); @(negedge clk);
    check("R7 new group after 4 edges", obs, gval(2, 5));

    // R8 bundle change while pin steady
    bus = make_bus(40);
    @(posedge clk); @(negedge clk);
    check("R8 follows bundle", obs, gval(2, 40));
    repeat (10) @(posedge clk);
    @(negedge clk) check("R8 steady pin holds", obs, gval(2, 40));

    // R6 every group mapping with a fresh pattern
    bus = make_bus(17);
    for (int k = 3; k < NG + 3; k++) begin
      step_to(~pin);
      check("R6 group mapping", obs, gval(k % NG, 17));
    end

    // R2 reset with pin changed during reset
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) pin = ~pin;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk) check("R2 no step from reset", obs, gval(0, 17));
    step_to(~pin);
    check("R2 first real toggle", obs, gval(1, 17));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule